// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds several copies of one register behind a single bus offset, one copy per hardware unit, organised as a grid of groups by instances. A steering selector register, at its own offset, carries a group number, an instance number and a broadcast flag. The broadcast flag decides how writes to the shared offset are applied. When it is set, the write goes to every live copy. When it is clear, the write goes only to the copy that the group and instance fields select. A read of the shared offset always returns exactly one copy, the steered one, whatever the broadcast flag holds.

Two static mask vectors, one for fused-off units and one for power-gated units, mark copies as unreachable. An access aimed at an unreachable copy is absorbed without any error: a read of it returns zero, and a write to it changes nothing. Steering values beyond the configured grid are handled the same way. The block does not choose a steering target and does not arbitrate between agents. It only stores the selector and the copies, and it applies the masks. Reads respond one cycle after they are issued.

The block has no state machine. Its behaviour comes from a selector register, a write-enable fan-out across the copies, and a registered read multiplexer. Copy `k` is addressed as `group * INSTS + instance`, and bit `k` of each mask belongs to that copy.

Top module: `steered_rep_bank`

## Requirements
- R1: After reset the selector reads back as 0x8000_0000 (broadcast flag 1, group 0, instance 0), and every copy holds 0.
- R2: The selector sits at offset `SEL_OFF`. It stores instance ID in bits [7:0], group ID in bits [15:8] and the broadcast flag in bit 31. The remaining bits read as 0, and the selector changes only when written.
- R3: A write to offset `REP_OFF` with the broadcast flag set loads the write data into every live copy.
- R4: A write to `REP_OFF` with the broadcast flag clear loads only copy `group*INSTS+instance`.
- R5: A read of `REP_OFF` returns the steered copy whatever the broadcast flag holds. `bus_rdata` is valid in the cycle after `bus_rd`.
- R6: A copy is dead when its bit in `fuse_mask` or in `gate_mask` is 1. A read steered to a dead copy returns 0.
- R7: A narrowcast write steered to a dead copy changes no copy.
- R8: A broadcast write leaves dead copies unchanged.
- R9: A group ID of `GROUPS` or more, or an instance ID of `INSTS` or more, is treated as dead for both reads and narrowcast writes.
- R10: When `bus_wr` and `bus_rd` are both high in one cycle, the read returns the state from before that write, for the selector and for the copies alike.
- R11: Any other offset reads as 0, and a write to it changes neither the selector nor any copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Access offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| fuse_mask | input | GROUPS*INSTS | 1 marks a fused-off copy |
| gate_mask | input | GROUPS*INSTS | 1 marks a power-gated copy |

## Verification
A read and a write can land in the same cycle at the same offset. This covers a selector write that re-steers while the selector is read back, and a copy write that overlaps the read of the copy it replaces. The bench issues such combined accesses both in directed cases and at random. A reference model produces the expected read value from the state before the cycle, and only then applies the write. Any leak of the new value into that read is reported against R10.

// File: rtl/srb_pkg.sv
package srb_pkg;
    localparam int BUS_W = 32;
    localparam int FLD_W = 8;

    typedef struct packed {
        logic             bcast;
        logic [FLD_W-1:0] grp;
        logic [FLD_W-1:0] inst;
    } steer_t;

    localparam steer_t STEER_RST = '{bcast: 1'b1, grp: '0, inst: '0};

    function automatic logic [BUS_W-1:0] steer_to_word(steer_t s);
        return {s.bcast, 15'b0, s.grp, s.inst};
    endfunction

    function automatic steer_t word_to_steer(logic [BUS_W-1:0] w);
        steer_t s;
        s.bcast = w[31];
        s.grp   = w[15:8];
        s.inst  = w[7:0];
        return s;
    endfunction
endpackage

// File: rtl/srb_selector.sv
module srb_selector
    import srb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BUS_W-1:0] wdata,
    output steer_t           sel
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel <= STEER_RST;
        else if (load)
            sel <= word_to_steer(wdata);
    end

    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(sel));
endmodule

// File: rtl/srb_target.sv
module srb_target
    import srb_pkg::*;
#(
    parameter int GROUPS = 2,
    parameter int INSTS  = 4,
    localparam int NCOPY = GROUPS * INSTS,
    localparam int IDX_W = (NCOPY > 1) ? $clog2(NCOPY) : 1
)(
    input  steer_t           sel,
    input  logic [NCOPY-1:0] fuse_mask,
    input  logic [NCOPY-1:0] gate_mask,
    output logic [IDX_W-1:0] tgt_idx,
    output logic             tgt_live,
    output logic [NCOPY-1:0] live_vec
);
    logic        in_grid;
    logic [31:0] flat;

    always_comb begin
        live_vec = ~(fuse_mask | gate_mask);
        in_grid  = (32'(sel.grp) < 32'(GROUPS)) && (32'(sel.inst) < 32'(INSTS));
        flat     = 32'(sel.grp) * 32'(INSTS) + 32'(sel.inst);
        tgt_idx  = in_grid ? flat[IDX_W-1:0] : '0;
        tgt_live = in_grid && live_vec[tgt_idx];
    end
endmodule

// File: rtl/srb_storage.sv
module srb_storage
    import srb_pkg::*;
#(
    parameter int NCOPY = 8,
    localparam int IDX_W = (NCOPY > 1) ? $clog2(NCOPY) : 1
)(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        bcast,
    input  logic [IDX_W-1:0]            tgt_idx,
    input  logic                        tgt_live,
    input  logic [NCOPY-1:0]            live_vec,
    input  logic [BUS_W-1:0]            wdata,
    output logic [NCOPY-1:0][BUS_W-1:0] copy_q
);
    for (genvar k = 0; k < NCOPY; k++) begin : g_copy
        logic hit;
        assign hit = wr_en && (bcast ? live_vec[k]
                                     : (tgt_live && (tgt_idx == IDX_W'(k))));

        always_ff @(posedge clk) begin
            if (!rst_n)
                copy_q[k] <= '0;
            else if (hit)
                copy_q[k] <= wdata;
        end

        // R7 R8
        dead_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !live_vec[k]) |=> $stable(copy_q[k]));

        // R3
        bcast_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && bcast && live_vec[k]) |=> (copy_q[k] == $past(wdata)));
    end
endmodule

// File: rtl/steered_rep_bank.sv
module steered_rep_bank
    import srb_pkg::*;
#(
    parameter int              GROUPS  = 2,
    parameter int              INSTS   = 4,
    parameter int              ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] SEL_OFF = 8'h00,
    parameter logic [ADDR_W-1:0] REP_OFF = 8'h04,
    localparam int NCOPY = GROUPS * INSTS,
    localparam int IDX_W = (NCOPY > 1) ? $clog2(NCOPY) : 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NCOPY-1:0]  fuse_mask,
    input  logic [NCOPY-1:0]  gate_mask
);
    steer_t                       sel;
    logic [IDX_W-1:0]             tgt_idx;
    logic                         tgt_live;
    logic [NCOPY-1:0]             live_vec;
    logic [NCOPY-1:0][BUS_W-1:0]  copy_q;
    logic                         hit_sel, hit_rep;
    logic [BUS_W-1:0]             rd_next;

    assign hit_sel = (bus_addr == SEL_OFF);
    assign hit_rep = (bus_addr == REP_OFF);

    srb_selector u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (bus_wr && hit_sel),
        .wdata (bus_wdata),
        .sel   (sel)
    );

    srb_target #(.GROUPS(GROUPS), .INSTS(INSTS)) u_tgt (
        .sel       (sel),
        .fuse_mask (fuse_mask),
        .gate_mask (gate_mask),
        .tgt_idx   (tgt_idx),
        .tgt_live  (tgt_live),
        .live_vec  (live_vec)
    );

    srb_storage #(.NCOPY(NCOPY)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr && hit_rep),
        .bcast    (sel.bcast),
        .tgt_idx  (tgt_idx),
        .tgt_live (tgt_live),
        .live_vec (live_vec),
        .wdata    (bus_wdata),
        .copy_q   (copy_q)
    );

    always_comb begin
        rd_next = '0;
        if (hit_sel)
            rd_next = steer_to_word(sel);
        else if (hit_rep && tgt_live)
            rd_next = copy_q[tgt_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_next;
    end

    // R6 R9
    dead_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit_rep && !tgt_live) |=> (bus_rdata == '0));

    // R11
    other_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit_rep && !hit_sel) |=> (bus_rdata == '0));

    // R10
    sel_read_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit_sel) |=> (bus_rdata == steer_to_word($past(sel))));
endmodule

// File: tb/steered_rep_bank_tb_top.sv
`timescale 1ns/1ps
module steered_rep_bank_tb_top;
    localparam int GROUPS = 2;
    localparam int INSTS  = 4;
    localparam int NCOPY  = GROUPS * INSTS;
    localparam logic [7:0] SEL = 8'h00;
    localparam logic [7:0] REP = 8'h04;
    localparam logic [7:0] OTH = 8'h10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       bus_addr = '0;
    logic             bus_wr = 1'b0;
    logic             bus_rd = 1'b0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [NCOPY-1:0] fuse_mask = '0;
    logic [NCOPY-1:0] gate_mask = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_copy [NCOPY];
    logic        m_bc;
    logic [7:0]  m_grp, m_inst;

    always #2.5 clk = ~clk;

    steered_rep_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fuse_mask(fuse_mask), .gate_mask(gate_mask)
    );

    function automatic bit m_live(int k);
        return !fuse_mask[k] && !gate_mask[k];
    endfunction

    function automatic bit m_in_grid();
        return (int'(m_grp) < GROUPS) && (int'(m_inst) < INSTS);
    endfunction

    function automatic int m_idx();
        return int'(m_grp) * INSTS + int'(m_inst);
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        if (a == SEL) return {m_bc, 15'b0, m_grp, m_inst};
        if (a == REP && m_in_grid() && m_live(m_idx())) return m_copy[m_idx()];
        return 32'h0;
    endfunction

    task automatic m_write(logic [7:0] a, logic [31:0] d);
        if (a == SEL) begin
            m_bc = d[31]; m_grp = d[15:8]; m_inst = d[7:0];
        end else if (a == REP) begin
            if (m_bc) begin
                for (int k = 0; k < NCOPY; k++) if (m_live(k)) m_copy[k] = d;
            end else if (m_in_grid() && m_live(m_idx())) begin
                m_copy[m_idx()] = d;
            end
        end
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // one access, inputs driven at negedge, result sampled at the next negedge
    task automatic access(bit wr, bit rd, logic [7:0] a, logic [31:0] d, string tag);
        logic [31:0] exp;
        exp = m_read(a);
        if (wr) m_write(a, d);
        bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        if (rd) check(tag, bus_rdata, exp);
    endtask

    task automatic steer(bit bc, int g, int i);
        access(1'b1, 1'b0, SEL, {bc, 15'h0, 8'(g), 8'(i)}, "R2");
    endtask

    task automatic read_all(string tag);
        for (int g = 0; g < GROUPS; g++)
            for (int i = 0; i < INSTS; i++) begin
                steer(1'b1, g, i);
                access(1'b0, 1'b1, REP, 32'h0, tag);
            end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < NCOPY; k++) m_copy[k] = '0;
        m_bc = 1'b1; m_grp = '0; m_inst = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        access(1'b0, 1'b1, SEL, 32'h0, "R1");
        check("R1 value", bus_rdata, 32'h8000_0000);
        read_all("R1");

        // R2 layout: reserved bits read back as zero
        access(1'b1, 1'b0, SEL, 32'hFFFF_0102, "R2");
        access(1'b0, 1'b1, SEL, 32'h0, "R2");
        check("R2 fields", bus_rdata, 32'h8000_0102);

        // R3 broadcast
        steer(1'b1, 0, 0);
        access(1'b1, 1'b0, REP, 32'hA5A5_0001, "R3");
        read_all("R3");

        // R4 / R5 narrowcast, then read with flag clear
        steer(1'b0, 1, 2);
        access(1'b1, 1'b0, REP, 32'h0000_1234, "R4");
        access(1'b0, 1'b1, REP, 32'h0, "R5");
        check("R5 steered", bus_rdata, 32'h0000_1234);
        read_all("R4");

        // R6 / R7 fused and gated copies
        fuse_mask = 8'b0000_1000;
        gate_mask = 8'b0010_0000;
        steer(1'b0, 0, 3);
        access(1'b0, 1'b1, REP, 32'h0, "R6");
        check("R6 fused zero", bus_rdata, 32'h0);
        access(1'b1, 1'b0, REP, 32'hDEAD_0003, "R7");
        steer(1'b0, 1, 1);
        access(1'b0, 1'b1, REP, 32'h0, "R6");
        access(1'b1, 1'b0, REP, 32'hDEAD_0005, "R7");
        // R8 broadcast skips dead copies
        steer(1'b1, 0, 0);
        access(1'b1, 1'b0, REP, 32'h5555_7777, "R8");
        fuse_mask = '0; gate_mask = '0;
        read_all("R7 R8");

        // R9 out of grid steering
        steer(1'b0, GROUPS, 0);
        access(1'b0, 1'b1, REP, 32'h0, "R9");
        access(1'b1, 1'b0, REP, 32'hBAD0_0000, "R9");
        steer(1'b0, 0, INSTS);
        access(1'b0, 1'b1, REP, 32'h0, "R9");
        access(1'b1, 1'b0, REP, 32'hBAD0_0001, "R9");
        read_all("R9");

        // R10 read and write in one cycle
        steer(1'b0, 1, 3);
        access(1'b1, 1'b1, REP, 32'h1111_2222, "R10");
        access(1'b0, 1'b1, REP, 32'h0, "R10");
        access(1'b1, 1'b1, SEL, 32'h8000_0001, "R10");
        access(1'b0, 1'b1, SEL, 32'h0, "R10");

        // R11 other offsets
        access(1'b1, 1'b1, OTH, 32'hFFFF_FFFF, "R11");
        access(1'b0, 1'b1, SEL, 32'h0, "R11");
        read_all("R11");

        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            int pick;
            logic [7:0] a;
            logic [31:0] d;
            bit wr, rd;
            pick = int'($urandom % 10);
            a = (pick < 3) ? SEL : (pick < 9) ? REP : OTH;
            wr = 1'($urandom % 2);
            rd = 1'($urandom % 2) | !wr;
            d = $urandom;
            if (a == SEL) begin
                d[15:8] = 8'($urandom % (GROUPS + 1));
                d[7:0]  = 8'($urandom % (INSTS + 1));
            end
            if ($urandom % 25 == 0) begin
                fuse_mask = NCOPY'($urandom) & NCOPY'($urandom);
                gate_mask = NCOPY'($urandom) & NCOPY'($urandom);
            end
            access(wr, rd, a, d, (wr && rd) ? "R10 random" : "R5 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule